// File: doc/BRIEF.md
# External Memory Transaction Splitter

This block sits between a 32-bit internal request port and an engine that performs single accesses on a 16-bit external NOR Flash or PSRAM bus. Each request carries a direction, a size (byte, halfword or word), a byte address, write data, a device kind, an access mode and a chip-select bank. The block first checks the request against a fixed legality table. A request that fails the check gets an error response and never reaches the memory side.

A legal request becomes one 16-bit memory access, or two when it is 32 bits wide. For a word, the lower halfword is moved first and the upper halfword second, one access after the other. On a read, the two halves are joined into a single 32-bit response. The block also drives the byte-lane enables and the chip selects for each access. Pin timing, address/data multiplexing and wait states are left to the downstream engine, which signals the end of each access with a one-cycle acknowledge.

Top module: `xmem_split`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_valid` and `rsp_valid` are 0, `mem_bl_n` is 2'b11 and every bit of `mem_cs_n` is 1.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word. Device codes are 0 = NOR Flash, 1 = PSRAM. Mode codes are 0 = asynchronous, 1 = asynchronous page, 2 = synchronous. In asynchronous mode every read and write is legal, except a byte write to NOR Flash, which is rejected.
- R3: Every request in page mode (code 1) or in the unused mode code 3 is rejected.
- R4: In synchronous mode, byte reads are rejected and halfword and word reads are accepted. Synchronous writes are rejected for NOR Flash and accepted for PSRAM.
- R5: Size code 3 is rejected. A halfword with address bit 0 set is rejected. A word with either of address bits 1:0 set is rejected.
- R6: A rejected request raises `rsp_valid` with `rsp_err` = 1 one cycle after it is accepted. `mem_valid` is never raised for it.
- R7: A legal word request makes exactly two memory accesses. The first is at the request address and carries write data bits 15:0. The second is at the address plus 2 and carries write data bits 31:16.
- R8: A word read returns {second halfword, first halfword} on `rsp_rdata`. The response comes only after the second acknowledge.
- R9: `mem_bl_n` is active low, and bit 0 is the lower byte (data bits 7:0). A byte access enables only the lane chosen by address bit 0. Halfword and word accesses enable both lanes.
- R10: While `mem_valid` is 1, exactly the bit of `mem_cs_n` selected by `req_bank` is 0. At all other times every bit is 1.
- R11: A byte write places write data bits 7:0 on both byte lanes of `mem_wdata`. A byte read returns the selected lane in `rsp_rdata[7:0]`. A halfword read returns its value in bits 15:0. All other result bits are 0.
- R12: `req_ready` is 0 while a memory access is in progress. `mem_addr` and `mem_wdata` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_dev | input | 1 | 0 NOR Flash, 1 PSRAM |
| req_mode | input | 2 | 0 async, 1 async page, 2 sync |
| req_bank | input | 2 | Chip-select bank |
| req_addr | input | 26 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read result |
| mem_valid | output | 1 | Memory access requested |
| mem_ack | input | 1 | Memory access finished |
| mem_write | output | 1 | Access direction |
| mem_addr | output | 26 | Access byte address |
| mem_wdata | output | 16 | Access write data |
| mem_rdata | input | 16 | Access read data |
| mem_bl_n | output | 2 | Byte-lane enables, active low |
| mem_cs_n | output | 4 | Chip selects, active low |

## Verification
The hardest case to reach is the pause between the two halves of a word read. The block must keep the first halfword, keep `req_ready` low and leave the second address steady while the engine is still stalling. The bench reaches this case with a memory model whose acknowledge latency can be set per scenario. It runs word reads under a multi-cycle latency and checks the address stability and the ready level on every stalled cycle. It also checks that the response arrives only after two logged accesses.

// File: rtl/xms_pkg.sv
package xms_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xms_size_e;

  typedef enum logic [1:0] {
    MD_ASYNC = 2'd0,
    MD_PAGE  = 2'd1,
    MD_SYNC  = 2'd2,
    MD_RSVD  = 2'd3
  } xms_mode_e;

  typedef enum logic {
    DEV_NOR   = 1'b0,
    DEV_PSRAM = 1'b1
  } xms_dev_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } xms_state_e;
endpackage

// File: rtl/xms_legal_chk.sv
module xms_legal_chk
  import xms_pkg::*;
(
  input  logic       write,
  input  xms_size_e  size,
  input  xms_dev_e   dev,
  input  xms_mode_e  mode,
  input  logic [1:0] addr_lo,
  output logic       ok
);
  logic table_ok;
  logic aligned;

  always_comb begin
    case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~addr_lo[0];
      SZ_WORD: aligned = (addr_lo == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  always_comb begin
    table_ok = 1'b0;
    case (mode)
      MD_ASYNC: table_ok = ~(write && (size == SZ_BYTE) && (dev == DEV_NOR));
      MD_SYNC: begin
        if (write) table_ok = (dev == DEV_PSRAM);
        else       table_ok = (size != SZ_BYTE);
      end
      default: table_ok = 1'b0;
    endcase
  end

  assign ok = table_ok && aligned && (size != SZ_RSVD);
endmodule

// File: rtl/xms_lane_gen.sv
module xms_lane_gen
  import xms_pkg::*;
#(
  parameter int AW  = 26,
  parameter int DW  = 32,
  parameter int NCS = 4,
  localparam int HW  = DW / 2,
  localparam int CSW = $clog2(NCS)
) (
  input  logic           active,
  input  logic           second,
  input  xms_size_e      size,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  input  logic [CSW-1:0] bank,
  output logic [AW-1:0]  mem_addr,
  output logic [HW-1:0]  mem_wdata,
  output logic [1:0]     bl_n,
  output logic [NCS-1:0] cs_n
);
  assign mem_addr = second ? {addr[AW-1:2], 2'b10} : addr;

  always_comb begin
    case (size)
      SZ_BYTE: mem_wdata = {wdata[7:0], wdata[7:0]};
      SZ_WORD: mem_wdata = second ? wdata[DW-1:HW] : wdata[HW-1:0];
      default: mem_wdata = wdata[HW-1:0];
    endcase
  end

  always_comb begin
    if (!active)               bl_n = 2'b11;
    else if (size == SZ_BYTE)  bl_n = addr[0] ? 2'b01 : 2'b10;
    else                       bl_n = 2'b00;
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = ~(active && (bank == CSW'(g)));
  end

  always_comb begin
    // R9
    if (active) lane_on_chk: assert (bl_n != 2'b11);
    // R10
    if (active) cs_single_chk: assert ($countones(~cs_n) == 1);
    else if (!active) cs_quiet_chk: assert (&cs_n);
  end
endmodule

// File: rtl/xms_seq.sv
module xms_seq
  import xms_pkg::*;
#(
  parameter int DW = 32,
  localparam int HW = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_ok,
  input  xms_size_e     size_q,
  input  logic          write_q,
  input  logic          addr0_q,
  input  logic          mem_ack,
  input  logic [HW-1:0] mem_rdata,
  output logic          req_ready,
  output logic          mem_valid,
  output logic          second,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  xms_state_e    state_q, state_d;
  logic [HW-1:0] lo_q;
  logic          lo_en;
  logic          rsp_v_d, rsp_e_d;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] narrow;

  always_comb begin
    case (size_q)
      SZ_BYTE: narrow = {{(DW-8){1'b0}}, addr0_q ? mem_rdata[15:8] : mem_rdata[7:0]};
      default: narrow = {{(DW-HW){1'b0}}, mem_rdata};
    endcase
  end

  always_comb begin
    state_d = state_q;
    lo_en   = 1'b0;
    rsp_v_d = 1'b0;
    rsp_e_d = 1'b0;
    rdata_d = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_ok) begin
            state_d = ST_FIRST;
          end else begin
            rsp_v_d = 1'b1;
            rsp_e_d = 1'b1;
          end
        end
      end
      ST_FIRST: begin
        if (mem_ack) begin
          if (size_q == SZ_WORD) begin
            state_d = ST_SECOND;
            lo_en   = 1'b1;
          end else begin
            state_d = ST_IDLE;
            rsp_v_d = 1'b1;
            rdata_d = write_q ? '0 : narrow;
          end
        end
      end
      ST_SECOND: begin
        if (mem_ack) begin
          state_d = ST_IDLE;
          rsp_v_d = 1'b1;
          rdata_d = write_q ? '0 : {mem_rdata, lo_q};
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_v_d;
      rsp_err   <= rsp_e_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_q <= '0;
    else if (lo_en)   lo_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rsp_rdata <= '0;
    else if (rsp_v_d)  rsp_rdata <= rdata_d;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_valid = (state_q != ST_IDLE);
  assign second    = (state_q == ST_SECOND);

  // R8
  ok_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err |-> $past(mem_ack));

  // R12
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ack |=> mem_valid && !req_ready);
endmodule

// File: rtl/xmem_split.sv
module xmem_split
  import xms_pkg::*;
#(
  parameter int AW  = 26,
  parameter int DW  = 32,
  parameter int NCS = 4,
  localparam int HW  = DW / 2,
  localparam int CSW = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [1:0]     req_size,
  input  logic           req_dev,
  input  logic [1:0]     req_mode,
  input  logic [CSW-1:0] req_bank,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [DW-1:0]  rsp_rdata,
  output logic           mem_valid,
  input  logic           mem_ack,
  output logic           mem_write,
  output logic [AW-1:0]  mem_addr,
  output logic [HW-1:0]  mem_wdata,
  input  logic [HW-1:0]  mem_rdata,
  output logic [1:0]     mem_bl_n,
  output logic [NCS-1:0] mem_cs_n
);
  logic [1:0]     rst_sync_q;
  logic           rst_i_n;
  logic           req_ok;
  logic           take;
  logic           second;
  logic           write_q;
  xms_size_e      size_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [CSW-1:0] bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign take = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      write_q <= 1'b0;
      size_q  <= SZ_BYTE;
      addr_q  <= '0;
      wdata_q <= '0;
      bank_q  <= '0;
    end else if (take) begin
      write_q <= req_write;
      size_q  <= xms_size_e'(req_size);
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      bank_q  <= req_bank;
    end
  end

  xms_legal_chk u_legal (
    .write   (req_write),
    .size    (xms_size_e'(req_size)),
    .dev     (xms_dev_e'(req_dev)),
    .mode    (xms_mode_e'(req_mode)),
    .addr_lo (req_addr[1:0]),
    .ok      (req_ok)
  );

  xms_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .req_ok    (req_ok),
    .size_q    (size_q),
    .write_q   (write_q),
    .addr0_q   (addr_q[0]),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .req_ready (req_ready),
    .mem_valid (mem_valid),
    .second    (second),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

  xms_lane_gen #(.AW(AW), .DW(DW), .NCS(NCS)) u_lane (
    .active    (mem_valid),
    .second    (second),
    .size      (size_q),
    .addr      (addr_q),
    .wdata     (wdata_q),
    .bank      (bank_q),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .bl_n      (mem_bl_n),
    .cs_n      (mem_cs_n)
  );

  assign mem_write = write_q;

  // R6
  rej_no_access_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_valid && rsp_err |-> !mem_valid);

  // R7
  split_step_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(second) |-> mem_addr == $past(mem_addr) + AW'(2));

  // R12
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    mem_valid && !mem_ack |=> $stable(mem_addr) && $stable(mem_wdata));

  // R3
  page_rej_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    take && (req_mode == 2'd1) |=> !mem_valid);
endmodule

// File: tb/xmem_split_test.sv
module xmem_split_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_dev = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic [1:0]  req_bank = 2'd0;
  logic [25:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write;
  logic        mem_ack = 1'b0;
  logic [25:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  mem_bl_n;
  logic [3:0]  mem_cs_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] mem [0:63];
  int          lat = 0;
  int          wait_cnt = 0;
  logic [25:0] hold_addr;
  int          bad_stall = 0;
  int          log_n = 0;
  logic [25:0] log_addr [0:3];
  logic [15:0] log_wd [0:3];
  logic [1:0]  log_bl [0:3];
  logic [3:0]  log_cs [0:3];
  logic        log_we [0:3];

  int          cyc = 0;
  int          acc_cyc = 0;
  int          rsp_cyc = 0;
  bit          rsp_seen = 0;
  logic        rsp_e_s;
  logic [31:0] rsp_d_s;
  int          log_at_rsp = 0;

  xmem_split uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_dev(req_dev), .req_mode(req_mode),
    .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ack(mem_ack), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_bl_n(mem_bl_n), .mem_cs_n(mem_cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] init_word(int i);
    return {8'(i) ^ 8'h5A, 8'(i)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (req_valid && req_ready) acc_cyc <= cyc;
  end

  always @(negedge clk) begin
    if (rsp_valid) begin
      rsp_seen   = 1;
      rsp_e_s    = rsp_err;
      rsp_d_s    = rsp_rdata;
      rsp_cyc    = cyc;
      log_at_rsp = log_n;
    end
  end

  // memory model: acknowledges after lat stalled cycles
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_valid) begin
      if (req_ready) bad_stall++;
      if (wait_cnt > 0 && mem_addr != hold_addr) bad_stall++;
      if (wait_cnt < lat) begin
        hold_addr = mem_addr;
        wait_cnt++;
      end else begin
        wait_cnt = 0;
        if (mem_write) begin
          if (!mem_bl_n[0]) mem[mem_addr[6:1]][7:0]  = mem_wdata[7:0];
          if (!mem_bl_n[1]) mem[mem_addr[6:1]][15:8] = mem_wdata[15:8];
        end else begin
          mem_rdata = mem[mem_addr[6:1]];
        end
        if (log_n < 4) begin
          log_addr[log_n] = mem_addr;
          log_wd[log_n]   = mem_wdata;
          log_bl[log_n]   = mem_bl_n;
          log_cs[log_n]   = mem_cs_n;
          log_we[log_n]   = mem_write;
        end
        log_n++;
        mem_ack = 1'b1;
      end
    end
  end

  task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit w, input logic [1:0] sz, input bit dv, input logic [1:0] md,
                        input logic [1:0] bk, input logic [25:0] a, input logic [31:0] wd);
    @(negedge clk);
    log_n = 0;
    rsp_seen = 0;
    req_valid = 1'b1; req_write = w; req_size = sz; req_dev = dv;
    req_mode = md; req_bank = bk; req_addr = a; req_wdata = wd;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int i = 0; i < 200 && !rsp_seen; i++) @(negedge clk);
    check(rsp_seen, "R6 response missing", 32'(rsp_seen), 1);
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R1 ready", 32'(req_ready), 1);
    check(mem_valid === 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
    check(rsp_valid === 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    check(mem_bl_n === 2'b11, "R1 bl_n", 32'(mem_bl_n), 3);
    check(mem_cs_n === 4'hF, "R1 cs_n", 32'(mem_cs_n), 15);
  endtask

  task automatic t_half;
    lat = 0;
    do_req(1, 2'd1, 0, 2'd0, 2'd0, 26'h10, 32'hDEAD_BEEF);
    check(!rsp_e_s, "R2 nor async half write ok", 32'(rsp_e_s), 0);
    check(log_at_rsp == 1, "R7 half one access", log_at_rsp, 1);
    check(log_addr[0] == 26'h10, "R7 half addr", 32'(log_addr[0]), 32'h10);
    check(log_wd[0] == 16'hBEEF, "R11 half wdata", 32'(log_wd[0]), 32'hBEEF);
    check(log_bl[0] == 2'b00, "R9 half lanes", 32'(log_bl[0]), 0);
    check(log_cs[0] == 4'b1110, "R10 bank0", 32'(log_cs[0]), 32'hE);
    do_req(0, 2'd1, 0, 2'd0, 2'd0, 26'h10, 32'h0);
    check(rsp_d_s == 32'h0000_BEEF, "R11 half read", rsp_d_s, 32'hBEEF);
  endtask

  task automatic t_word;
    lat = 0;
    do_req(1, 2'd2, 1, 2'd2, 2'd2, 26'h20, 32'h1234_5678);
    check(!rsp_e_s, "R4 psram sync write ok", 32'(rsp_e_s), 0);
    check(log_at_rsp == 2, "R7 two accesses", log_at_rsp, 2);
    check(log_addr[0] == 26'h20 && log_addr[1] == 26'h22, "R7 addr order",
          32'(log_addr[1]), 32'h22);
    check(log_wd[0] == 16'h5678 && log_wd[1] == 16'h1234, "R7 halves order",
          {log_wd[1], log_wd[0]}, 32'h1234_5678);
    check(log_cs[1] == 4'b1011, "R10 bank2", 32'(log_cs[1]), 32'hB);
    lat = 3;
    do_req(0, 2'd2, 0, 2'd2, 2'd2, 26'h20, 32'h0);
    check(rsp_d_s == 32'h1234_5678, "R8 word reassembly", rsp_d_s, 32'h1234_5678);
    check(log_at_rsp == 2, "R8 resp after second ack", log_at_rsp, 2);
    check(bad_stall == 0, "R12 stall hold", bad_stall, 0);
    lat = 0;
  endtask

  task automatic t_byte;
    logic [15:0] w;
    lat = 1;
    do_req(1, 2'd0, 1, 2'd0, 2'd1, 26'h31, 32'h0000_00C3);
    check(!rsp_e_s, "R2 psram byte write ok", 32'(rsp_e_s), 0);
    check(log_bl[0] == 2'b01, "R9 upper lane", 32'(log_bl[0]), 1);
    check(log_wd[0] == 16'hC3C3, "R11 byte replicated", 32'(log_wd[0]), 32'hC3C3);
    w = {8'hC3, init_word(24)[7:0]};
    do_req(0, 2'd1, 1, 2'd0, 2'd1, 26'h30, 32'h0);
    check(rsp_d_s == {16'h0, w}, "R9 only upper byte written", rsp_d_s, {16'h0, w});
    do_req(0, 2'd0, 0, 2'd0, 2'd3, 26'h31, 32'h0);
    check(rsp_d_s == 32'hC3, "R11 byte read upper", rsp_d_s, 32'hC3);
    check(log_bl[0] == 2'b01 && log_cs[0] == 4'b0111, "R10 bank3 upper lane",
          {log_cs[0], log_bl[0]}, 32'h1D);
    do_req(0, 2'd0, 0, 2'd0, 2'd3, 26'h30, 32'h0);
    check(rsp_d_s == {24'h0, w[7:0]}, "R11 byte read lower", rsp_d_s, {24'h0, w[7:0]});
    check(log_bl[0] == 2'b10, "R9 lower lane", 32'(log_bl[0]), 2);
    lat = 0;
  endtask

  task automatic rej(input bit w, input logic [1:0] sz, input bit dv, input logic [1:0] md,
                     input logic [25:0] a, input string tag);
    do_req(w, sz, dv, md, 2'd0, a, 32'hFFFF_FFFF);
    check(rsp_e_s === 1'b1, tag, 32'(rsp_e_s), 1);
    check(log_n == 0, "R6 no memory access", log_n, 0);
    check(rsp_cyc - acc_cyc == 1, "R6 one-cycle error", rsp_cyc - acc_cyc, 1);
  endtask

  task automatic t_illegal;
    rej(1, 2'd0, 0, 2'd0, 26'h4, "R2 nor async byte write");
    rej(0, 2'd1, 0, 2'd1, 26'h4, "R3 page read");
    rej(0, 2'd1, 1, 2'd3, 26'h4, "R3 mode 3");
    rej(0, 2'd0, 1, 2'd2, 26'h4, "R4 sync byte read");
    rej(1, 2'd1, 0, 2'd2, 26'h4, "R4 nor sync write");
    rej(0, 2'd3, 0, 2'd0, 26'h4, "R5 size 3");
    rej(0, 2'd1, 0, 2'd0, 26'h5, "R5 odd halfword");
    rej(1, 2'd2, 1, 2'd0, 26'h6, "R5 misaligned word");
  endtask

  task automatic t_sync_ok;
    do_req(0, 2'd1, 0, 2'd2, 2'd0, 26'h10, 32'h0);
    check(!rsp_e_s && rsp_d_s == 32'hBEEF, "R4 sync half read", rsp_d_s, 32'hBEEF);
    do_req(0, 2'd0, 1, 2'd0, 2'd0, 26'h11, 32'h0);
    check(!rsp_e_s && rsp_d_s == 32'hBE, "R2 async byte read", rsp_d_s, 32'hBE);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_half();
    t_word();
    t_byte();
    t_illegal();
    t_sync_ok();
    repeat (3) @(negedge clk);
    check(mem_cs_n === 4'hF && mem_bl_n === 2'b11, "R10 idle selects", 32'(mem_cs_n), 15);
    finish_run();
  end
endmodule